// File: doc/BRIEF.md
# Stream-to-Memory Packet Writer Channel

This block is a single-direction DMA channel that lands one AXI4-Stream packet in system memory. Software writes a destination byte address and a byte limit through a small word-addressed register port. The write of a nonzero limit arms the channel. The channel then takes beats from the stream source and buffers them up to one burst. It pushes each burst out as an AXI4 incrementing write on the AW, W and B channels, and each burst begins where the previous one ended.

The packet ends on `s_tlast`, or early when the byte limit runs out. The stream side carries no address. When a packet closes normally, the channel replaces the limit in the length register with the number of valid bytes it took in, and raises a done flag once the final write response returns OKAY. A misaligned destination, a limit that is too small for the packet, or a bad write response raises an error flag instead. Either flag drives `irq` until software clears it.

Top module: `s2mm_chan`

## Requirements
- R1: The register map, by `reg_addr`, is:
  - 0: control. Bit 0 is the soft reset.
  - 1: status. Bit 0 is done, bit 1 is error, bit 2 is busy.
  - 2: destination byte address.
  - 3: length, with 14 valid bits, so the largest limit is 16383 bytes.

  While the channel is idle, writing a nonzero value to the length register arms it. Writing zero leaves it idle.
- R2: `s_tready` is high only while the channel is armed and collecting beats. It is low before arming, after the packet ends, and while a write burst is in flight.
- R3: Byte k of the packet is written to destination + k. Each beat's `m_wstrb` equals that beat's `s_tkeep`, so bytes whose keep bit is clear stay unwritten in memory.
- R4: When a packet ends on `s_tlast`, the length register reads back the sum of all `s_tkeep` bits received.
- R5: Every burst is incrementing with 4-byte beats. It has at most MAX_BURST beats and never crosses a MAX_BURST×4-byte aligned boundary, so the first burst is shortened when the base address sits inside such a window.
- R6: Once `m_awvalid` or `m_wvalid` is raised, it stays high with stable address, length, data, strobe and last until the matching ready is seen.
- R7: Done is set only in the cycle that the final write response is accepted with `m_bresp` = 0 (OKAY). A nonzero response sets error instead, never sets done, and returns the channel to idle.
- R8: At most ceil(limit/4) beats are accepted. If that count is reached without `s_tlast`, the following happens:
  - `s_tready` falls and the beats already taken are written.
  - Error is set and done is not.
  - The length register reads the bytes taken.
- R9: Arming with a destination whose two low bits are nonzero sets error at once and leaves the channel idle with `s_tready` low.
- R10: Writing 1 to control bit 0 aborts any transfer. From the next cycle `s_tready`, `m_awvalid`, `m_wvalid`, busy, done, error and `irq` are all low.
- R11: Writing 1 to status bit 0 or bit 1 clears done or error respectively, and a 0 leaves that flag alone. `irq` is high exactly when done or error is set.
- R12: Writes to the destination or length registers while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| s_tdata | input | 32 | Stream data |
| s_tkeep | input | 4 | Stream byte-valid mask |
| s_tlast | input | 1 | Stream end of packet |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat accepted |
| m_awaddr | output | 32 | Burst start address |
| m_awlen | output | 8 | Burst beats minus one |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write byte strobes |
| m_wlast | output | 1 | Last beat of burst |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| irq | output | 1 | Done or error pending |

## Verification
The hardest cases to reach are the ones where several kinds of packet end meet burst splitting. These are:
- a base address that sits a few beats short of a burst window, so the first burst must be cut short;
- a limit that runs out in the middle of a packet while that packet's last partial burst is still buffered.

The bench drives both cases. For the first it picks a destination 13 beats into a 16-beat window. For the second it sends a packet twice as long as the limit. A memory model on the write port records every burst length and every byte written, so burst sizes, strobes and untouched bytes can all be compared against values predicted from the requirements. A second directed sequence writes a new length in the middle of a packet, and a third issues a soft reset with a beat half collected.

// File: rtl/s2mm_chan.sv
`timescale 1ns/1ps
module s2mm_chan #(
  parameter int DW        = 32,
  parameter int AW        = 32,
  parameter int LEN_W     = 14,
  parameter int MAX_BURST = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [DW-1:0]     s_tdata,
  input  logic [DW/8-1:0]   s_tkeep,
  input  logic              s_tlast,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic [AW-1:0]     m_awaddr,
  output logic [7:0]        m_awlen,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [DW-1:0]     m_wdata,
  output logic [DW/8-1:0]   m_wstrb,
  output logic              m_wlast,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [1:0]        m_bresp,
  input  logic              m_bvalid,
  output logic              m_bready,
  output logic              irq
);
  localparam int KW  = DW / 8;
  localparam int OFF = $clog2(KW);
  localparam int BW  = $clog2(MAX_BURST);
  localparam int CW  = BW + 1;

  typedef enum logic [2:0] {IDLE, FILL, ADDR, DATA, RESP} st_t;
  st_t st;

  logic [AW-1:0]    dest_r, cur_addr;
  logic [LEN_W-1:0] len_r, beats_max, beats_acc, bytes_cnt;
  logic [CW-1:0]    fill_cnt;
  logic [BW-1:0]    rd_ptr;
  logic [DW+KW-1:0] buf_q [MAX_BURST];
  logic             seen_last, hit_limit, done_f, err_f;

  function automatic logic [OFF:0] pop(input logic [KW-1:0] k);
    pop = '0;
    for (int i = 0; i < KW; i++) pop = pop + (OFF+1)'(k[i]);
  endfunction

  wire              soft_rst = reg_we && reg_addr == 2'd0 && reg_wdata[0];
  wire [LEN_W-1:0]  wlen     = reg_wdata[LEN_W-1:0];
  wire [LEN_W:0]    cap_calc = ({1'b0, wlen} + (LEN_W+1)'(KW-1)) >> OFF;
  wire [CW-1:0]     room     = CW'(MAX_BURST) - {1'b0, cur_addr[OFF+BW-1:OFF]};
  wire              accept   = s_tvalid && s_tready;
  wire              at_limit = (beats_acc + LEN_W'(1)) == beats_max;
  wire              burst_end = s_tlast || at_limit || (fill_cnt + CW'(1) == room);

  assign s_tready  = st == FILL;
  assign m_awvalid = st == ADDR;
  assign m_wvalid  = st == DATA;
  assign m_bready  = st == RESP;
  assign m_awaddr  = cur_addr;
  assign m_awlen   = 8'(fill_cnt - CW'(1));
  assign {m_wstrb, m_wdata} = buf_q[rd_ptr];
  assign m_wlast   = (CW'(rd_ptr) + CW'(1)) == fill_cnt;
  assign irq       = done_f | err_f;

  always_comb begin
    case (reg_addr)
      2'd1:    reg_rdata = {29'd0, st != IDLE, err_f, done_f};
      2'd2:    reg_rdata = 32'(dest_r);
      2'd3:    reg_rdata = 32'(len_r);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk)
    if (accept) buf_q[fill_cnt[BW-1:0]] <= {s_tkeep, s_tdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; dest_r <= '0; cur_addr <= '0; len_r <= '0;
      beats_max <= '0; beats_acc <= '0; bytes_cnt <= '0;
      fill_cnt <= '0; rd_ptr <= '0;
      seen_last <= 1'b0; hit_limit <= 1'b0; done_f <= 1'b0; err_f <= 1'b0;
    end else if (soft_rst) begin
      st <= IDLE; fill_cnt <= '0; seen_last <= 1'b0; hit_limit <= 1'b0;
      done_f <= 1'b0; err_f <= 1'b0;
    end else begin
      if (reg_we && reg_addr == 2'd1) begin
        if (reg_wdata[0]) done_f <= 1'b0;
        if (reg_wdata[1]) err_f  <= 1'b0;
      end
      case (st)
        IDLE: begin
          if (reg_we && reg_addr == 2'd2) dest_r <= reg_wdata[AW-1:0];
          if (reg_we && reg_addr == 2'd3 && |wlen) begin
            if (|dest_r[OFF-1:0]) err_f <= 1'b1;
            else begin
              st <= FILL; len_r <= wlen; beats_max <= cap_calc[LEN_W-1:0];
              beats_acc <= '0; bytes_cnt <= '0; cur_addr <= dest_r;
              fill_cnt <= '0; seen_last <= 1'b0; hit_limit <= 1'b0;
            end
          end
        end
        FILL: if (accept) begin
          fill_cnt  <= fill_cnt + CW'(1);
          beats_acc <= beats_acc + LEN_W'(1);
          bytes_cnt <= bytes_cnt + LEN_W'(pop(s_tkeep));
          if (s_tlast) seen_last <= 1'b1;
          else if (at_limit) hit_limit <= 1'b1;
          if (burst_end) st <= ADDR;
        end
        ADDR: if (m_awready) begin st <= DATA; rd_ptr <= '0; end
        DATA: if (m_wready) begin
          rd_ptr <= rd_ptr + BW'(1);
          if (m_wlast) st <= RESP;
        end
        RESP: if (m_bvalid) begin
          if (m_bresp != 2'b00) begin
            err_f <= 1'b1; st <= IDLE;
          end else begin
            cur_addr <= cur_addr + (AW'(fill_cnt) << OFF);
            fill_cnt <= '0;
            if (seen_last || hit_limit) begin
              st <= IDLE; len_r <= bytes_cnt;
              if (hit_limit) err_f <= 1'b1;
              else done_f <= 1'b1;
            end else st <= FILL;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/s2mm_chan_chk.sv
`timescale 1ns/1ps
module s2mm_chan_chk #(
  parameter int DW        = 32,
  parameter int AW        = 32,
  parameter int LEN_W     = 14,
  parameter int MAX_BURST = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [1:0]      reg_addr,
  input logic [31:0]     reg_wdata,
  input logic            s_tready,
  input logic [AW-1:0]   m_awaddr,
  input logic [7:0]      m_awlen,
  input logic            m_awvalid,
  input logic            m_awready,
  input logic [DW-1:0]   m_wdata,
  input logic [DW/8-1:0] m_wstrb,
  input logic            m_wlast,
  input logic            m_wvalid,
  input logic            m_wready,
  input logic            m_bvalid,
  input logic            m_bready,
  input logic            irq
);
  localparam int OFF = $clog2(DW/8);
  localparam int BW  = $clog2(MAX_BURST);

  assert_no_ready_in_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s_tready |-> !m_awvalid && !m_wvalid && !m_bready);

  assert_burst_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid |-> (int'(m_awaddr[OFF+BW-1:OFF]) + int'(m_awlen)) < MAX_BURST
                  && m_awaddr[OFF-1:0] == '0);

  assert_aw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr) && $stable(m_awlen));

  assert_w_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata) && $stable(m_wstrb) && $stable(m_wlast));

  assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(m_bvalid && m_bready) || $past(reg_we && reg_addr == 2'd3));

  assert_soft_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && reg_addr == 2'd0 && reg_wdata[0] |=> !irq && !s_tready && !m_awvalid && !m_wvalid);
endmodule

bind s2mm_chan s2mm_chan_chk #(.DW(DW), .AW(AW), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST)) u_chk (.*);

// File: tb/s2mm_chan_tb.sv
`timescale 1ns/1ps
module s2mm_chan_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0; logic [1:0] reg_addr = '0; logic [31:0] reg_wdata = '0, reg_rdata;
  logic [31:0] s_tdata = '0; logic [3:0] s_tkeep = '0;
  logic s_tlast = 1'b0, s_tvalid = 1'b0, s_tready;
  logic [31:0] m_awaddr; logic [7:0] m_awlen; logic m_awvalid, m_awready = 1'b1;
  logic [31:0] m_wdata; logic [3:0] m_wstrb; logic m_wlast, m_wvalid, m_wready = 1'b1;
  logic [1:0] m_bresp = '0; logic m_bvalid = 1'b0, m_bready, irq;

  int checks = 0, errors = 0;
  logic [7:0] mem [0:4095];
  logic [7:0] aw_hist [0:255];
  int aw_cnt = 0, bnd_err = 0;
  logic [31:0] wa = '0;
  logic pend = 1'b0, stall = 1'b0;
  logic [1:0] bresp_cfg = 2'b00;

  always #2.5 clk = ~clk;

  s2mm_chan u_dut (.*);

  initial forever begin
    @(posedge clk);
    if (m_awvalid && m_awready) begin
      wa <= m_awaddr;
      aw_hist[aw_cnt[7:0]] <= m_awlen;
      aw_cnt <= aw_cnt + 1;
      if (int'(m_awaddr[5:2]) + int'(m_awlen) >= 16) bnd_err <= bnd_err + 1;
    end
    if (m_wvalid && m_wready) begin
      for (int b = 0; b < 4; b++)
        if (m_wstrb[b]) mem[(wa[11:0] + 12'(b))] <= m_wdata[8*b +: 8];
      wa <= wa + 32'd4;
      if (m_wlast) pend <= 1'b1;
    end
    if (m_bvalid && m_bready) m_bvalid <= 1'b0;
    else if (pend) begin m_bvalid <= 1'b1; m_bresp <= bresp_cfg; pend <= 1'b0; end
    m_awready <= stall ? ~m_awready : 1'b1;
    m_wready  <= stall ? ~m_wready  : 1'b1;
  end

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    reg_addr = a;
    @(negedge clk);
    d = int'(reg_rdata);
  endtask

  task automatic preset_mem(input int base, input int n);
    for (int i = 0; i < n; i++) mem[base + i] = 8'hEE;
  endtask

  task automatic push(input int nbeats, input int start, input logic [3:0] last_keep,
                      input bit use_last, output int taken);
    taken = 0;
    for (int i = 0; i < nbeats; i++) begin
      int g = 0;
      for (int b = 0; b < 4; b++) s_tdata[8*b +: 8] = 8'(start + 4*i + b);
      s_tkeep  = (i == nbeats-1) ? last_keep : 4'hF;
      s_tlast  = use_last && (i == nbeats-1);
      s_tvalid = 1'b1;
      while (!s_tready && g < 100) begin @(negedge clk); g++; end
      if (!s_tready) break;
      @(negedge clk);
      taken++;
    end
    s_tvalid = 1'b0; s_tlast = 1'b0;
  endtask

  task automatic wait_irq();
    for (int g = 0; g < 3000 && !irq; g++) @(negedge clk);
  endtask

  function automatic int mem_bad(input int base, input int n, input int start);
    int bad = 0;
    for (int i = 0; i < n; i++) if (mem[base + i] != 8'(start + i)) bad++;
    return bad;
  endfunction

  task automatic t_reset();
    int v;
    check_eq("R2 tready low after reset", int'(s_tready), 0);
    check_eq("R11 irq low after reset", int'(irq), 0);
    rd(2'd1, v); check_eq("R1 status zero after reset", v, 0);
    wr(2'd2, 32'h300); wr(2'd3, 32'd0);
    rd(2'd1, v); check_eq("R1 zero length does not arm", v, 0);
    check_eq("R2 tready low when not armed", int'(s_tready), 0);
  endtask

  task automatic t_basic();
    int v, tk, a0 = aw_cnt;
    preset_mem(32'h100, 260);
    wr(2'd2, 32'h100); wr(2'd3, 32'd256);
    push(64, 8'h0C, 4'hF, 1'b1, tk);
    wait_irq();
    rd(2'd1, v); check_eq("R7 done after full packet", v, 1);
    rd(2'd3, v); check_eq("R4 received count 256", v, 256);
    check_eq("R3 data in consecutive bytes", mem_bad(32'h100, 256, 8'h0C), 0);
    check_eq("R3 no write past packet", int'(mem[32'h200]), 8'hEE);
    check_eq("R5 four bursts", aw_cnt - a0, 4);
    check_eq("R5 full burst length", int'(aw_hist[a0[7:0]]), 15);
    wr(2'd1, 32'h2);
    check_eq("R11 writing error bit keeps done", int'(irq), 1);
    wr(2'd1, 32'h1);
    check_eq("R11 done cleared by W1C", int'(irq), 0);
  endtask

  task automatic t_partial();
    int v, tk;
    preset_mem(32'h204, 16);
    wr(2'd2, 32'h204); wr(2'd3, 32'd10);
    push(3, 8'h40, 4'b0011, 1'b1, tk);
    wait_irq();
    rd(2'd1, v); check_eq("R7 done partial packet", v, 1);
    rd(2'd3, v); check_eq("R4 count is tkeep sum 10", v, 10);
    check_eq("R3 partial bytes written", mem_bad(32'h204, 10, 8'h40), 0);
    check_eq("R3 strobe masks byte 10", int'(mem[32'h20E]), 8'hEE);
    check_eq("R3 strobe masks byte 11", int'(mem[32'h20F]), 8'hEE);
    wr(2'd1, 32'h3);
  endtask

  task automatic t_window();
    int v, tk, a0 = aw_cnt;
    stall = 1'b1;
    wr(2'd2, 32'h234); wr(2'd3, 32'd40);
    push(10, 8'h80, 4'hF, 1'b1, tk);
    wait_irq();
    stall = 1'b0;
    rd(2'd1, v); check_eq("R7 done with stalled slave", v, 1);
    check_eq("R5 split into two bursts", aw_cnt - a0, 2);
    check_eq("R5 first burst cut to window", int'(aw_hist[a0[7:0]]), 2);
    check_eq("R5 second burst length", int'(aw_hist[8'(a0 + 1)]), 6);
    check_eq("R5 no boundary crossing", bnd_err, 0);
    check_eq("R6 data intact under backpressure", mem_bad(32'h234, 40, 8'h80), 0);
    wr(2'd1, 32'h3);
  endtask

  task automatic t_overflow();
    int v, tk;
    preset_mem(32'h400, 40);
    wr(2'd2, 32'h400); wr(2'd3, 32'd16);
    push(8, 8'h20, 4'hF, 1'b1, tk);
    check_eq("R8 beats accepted capped at 4", tk, 4);
    wait_irq();
    rd(2'd1, v); check_eq("R8 error without done", v, 2);
    rd(2'd3, v); check_eq("R8 count of bytes taken", v, 16);
    check_eq("R8 taken bytes written", mem_bad(32'h400, 16, 8'h20), 0);
    check_eq("R8 nothing past limit", int'(mem[32'h410]), 8'hEE);
    check_eq("R2 tready low after overflow", int'(s_tready), 0);
    wr(2'd1, 32'h1);
    check_eq("R11 writing done bit keeps error", int'(irq), 1);
    wr(2'd1, 32'h2);
  endtask

  task automatic t_misalign();
    int v;
    wr(2'd2, 32'h302); wr(2'd3, 32'd8);
    rd(2'd1, v); check_eq("R9 misaligned sets error idle", v, 2);
    check_eq("R9 tready stays low", int'(s_tready), 0);
    check_eq("R11 irq on error", int'(irq), 1);
    wr(2'd1, 32'h2);
  endtask

  task automatic t_busy_write();
    int v, tk;
    wr(2'd2, 32'h480); wr(2'd3, 32'd64);
    push(2, 8'h60, 4'hF, 1'b0, tk);
    wr(2'd3, 32'd4); wr(2'd2, 32'h900);
    rd(2'd3, v); check_eq("R12 length write ignored while busy", v, 64);
    rd(2'd2, v); check_eq("R12 address write ignored while busy", v, 32'h480);
    push(3, 8'h68, 4'hF, 1'b1, tk);
    wait_irq();
    rd(2'd1, v); check_eq("R12 original limit still applies", v, 1);
    rd(2'd3, v); check_eq("R4 count after split pushes", v, 20);
    check_eq("R3 data at original address", mem_bad(32'h480, 20, 8'h60), 0);
    wr(2'd1, 32'h3);
  endtask

  task automatic t_bresp();
    int v, tk;
    bresp_cfg = 2'b10;
    wr(2'd2, 32'h500); wr(2'd3, 32'd8);
    push(2, 8'h90, 4'hF, 1'b1, tk);
    wait_irq();
    bresp_cfg = 2'b00;
    rd(2'd1, v); check_eq("R7 bad response gives error only", v, 2);
  endtask

  task automatic t_soft_reset();
    int v, tk;
    wr(2'd2, 32'h600); wr(2'd3, 32'd64);
    push(2, 8'hA0, 4'hF, 1'b0, tk);
    wr(2'd0, 32'h1);
    check_eq("R10 tready dropped", int'(s_tready), 0);
    check_eq("R10 irq cleared", int'(irq), 0);
    rd(2'd1, v); check_eq("R10 flags and busy cleared", v, 0);
    wr(2'd2, 32'h700); wr(2'd3, 32'd8);
    push(2, 8'hB0, 4'hF, 1'b1, tk);
    wait_irq();
    rd(2'd1, v); check_eq("R10 channel usable after abort", v, 1);
    rd(2'd3, v); check_eq("R4 count after abort", v, 8);
    wr(2'd1, 32'h3);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_partial();
    t_window();
    t_overflow();
    t_misalign();
    t_busy_write();
    t_bresp();
    t_soft_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule